// File: doc/BRIEF.md
# ATA Interrupt Request Controller

This block drives the device-side interrupt request line of an ATA-style storage device. It holds one pending-request flag. Event pulses from the device's command engine set or clear that flag. Host accesses to the task-file registers also clear it: a command-register write, or a status-register read made while the device is not busy.

The level presented to the host is the pending flag gated by an interrupt-disable bit, which the host writes through the device-control register. The gating is applied continuously. Setting the disable bit hides a request that is already pending without losing it. Clearing the bit again exposes that request with no new event.

Both the flag and the disable bit are registered, and the output is registered from them. The output therefore follows the state with one clock of latency.

Top module: `ata_irq_ctrl`

## Requirements
- R1: While the synchronous active-low reset is asserted, the pending flag and the disable bit are cleared, and `irq_o` is low on the first clock edge after reset is released.
- R2: A pulse on any `raise_i` bit, sampled at clock edge k, sets the pending flag at edge k. With the disable bit clear, `irq_o` goes high at edge k+1.
- R3: A raise while a request is already pending leaves the line steadily high, with no low cycle.
- R4: A pulse on any `clear_i` bit at edge k clears the pending flag, and `irq_o` falls at edge k+1.
- R5: A status-read strobe with `busy_i` low clears the pending flag.
- R6: A status-read strobe with `busy_i` high has no effect on the pending flag.
- R7: A command-register write strobe clears the pending flag.
- R8: A control-register write stores bit 1 of `ctl_data_i` as the disable bit (1 = disabled). While it is set, `irq_o` is low. The pending flag survives the write, so a later write with bit 1 clear drives `irq_o` high again without a new raise.
- R9: A raise that arrives while the disable bit is set still sets the pending flag. The request becomes visible once the bit is cleared.
- R10: When a raise and any clearing cause (clear pulse, command write, idle status read) occur in the same cycle, the raise wins and the flag ends set.
- R11: `irq_o` is low in any cycle that follows a cycle in which the pending flag was clear.
- R12: Bits of `ctl_data_i` other than bit 1 have no effect on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raise_i | input | N_SRC | Raise-request pulses from device-side sources |
| clear_i | input | N_SRC | Clear-request pulses from device-side sources |
| stat_rd_i | input | 1 | Host read of the status register (one-cycle strobe) |
| busy_i | input | 1 | Device busy bit as currently reported in status |
| cmd_wr_i | input | 1 | Host write of the command register (one-cycle strobe) |
| ctl_wr_i | input | 1 | Host write of the device-control register (one-cycle strobe) |
| ctl_data_i | input | CTL_W | Data of the control-register write |
| irq_o | output | 1 | Interrupt request level to the host |

## Verification
The flag is set and then removed by each clearing cause on its own: a device clear pulse, a command write, and status reads with busy both low and high. Comparing these shows which host accesses clear the flag and which are ignored. The disable bit is toggled both before and after a raise. This separates a stored request that is only hidden from one that has been lost. Simultaneous raise and clear patterns, plus control writes that touch only the other data bits, confirm the priority order and the single decoded bit.

// File: rtl/ata_irq_pkg.sv
// Package: shared types and defaults for the interrupt request controller.
// Assumes: one decoded disable bit inside the control-register data.
package ata_irq_pkg;

    // Default width of the device-control register data
    localparam int unsigned CTL_W_DEF    = 8;
    // Bit position of the interrupt-disable bit in control data
    localparam int unsigned DIS_BIT_DEF  = 1;

    // Combined event seen by the pending flag in one cycle
    typedef struct packed {
        logic set;
        logic clr;
    } pend_evt_t;

endpackage

// File: rtl/ata_irq_pend.sv
// Module: pending-request flag.
// Holds one bit. A set event has priority over a clear event in the same cycle.
// Assumes events are single-cycle pulses, synchronous to clk.
module ata_irq_pend
    import ata_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pend_evt_t evt_i,
    output logic      pend_o
);

    logic pend_q;

    // Update the flag: reset clears, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (evt_i.set)  pend_q <= 1'b1;
        else if (evt_i.clr)  pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/ata_irq_mask.sv
// Module: interrupt-disable bit captured from control-register writes.
// Only bit DIS_BIT of the write data is decoded; other bits are dropped.
// Assumes the write strobe lasts one cycle.
module ata_irq_mask #(
    parameter int unsigned CTL_W   = 8,
    parameter int unsigned DIS_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] data_i,
    output logic             dis_o
);

    logic dis_q;

    // Capture the disable bit on each control write
    always_ff @(posedge clk) begin
        if (!rst_n)     dis_q <= 1'b0;
        else if (wr_i)  dis_q <= data_i[DIS_BIT];
    end

    assign dis_o = dis_q;

endmodule

// File: rtl/ata_irq_out.sv
// Module: registered output stage.
// Presents the pending flag gated by the disable bit, one clock after the state.
// Assumes both inputs come from registers in the same clock domain.
module ata_irq_out (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic dis_i,
    output logic irq_o
);

    logic irq_q;

    // Register the gated request level
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pend_i & ~dis_i;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/ata_irq_ctrl.sv
// Module: top of the interrupt request controller.
// Merges the device-side raise/clear pulses with the host accesses that clear
// a request. It then keeps the pending flag and the disable bit, and drives
// the gated, registered request line.
// Assumes every strobe input is a single-cycle pulse synchronous to clk.
module ata_irq_ctrl
    import ata_irq_pkg::*;
#(
    parameter int unsigned N_SRC   = 2,
    parameter int unsigned CTL_W   = CTL_W_DEF,
    parameter int unsigned DIS_BIT = DIS_BIT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] raise_i,
    input  logic [N_SRC-1:0] clear_i,
    input  logic             stat_rd_i,
    input  logic             busy_i,
    input  logic             cmd_wr_i,
    input  logic             ctl_wr_i,
    input  logic [CTL_W-1:0] ctl_data_i,
    output logic             irq_o
);

    pend_evt_t evt;
    logic      host_clr;
    logic      pend_q;
    logic      dis_q;

    // Build the combined event: any raise source sets; any clear cause clears
    always_comb begin
        host_clr = cmd_wr_i | (stat_rd_i & ~busy_i);
        evt.set  = |raise_i;
        evt.clr  = (|clear_i) | host_clr;
    end

    ata_irq_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt),
        .pend_o (pend_q)
    );

    ata_irq_mask #(
        .CTL_W   (CTL_W),
        .DIS_BIT (DIS_BIT)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (ctl_wr_i),
        .data_i (ctl_data_i),
        .dis_o  (dis_q)
    );

    ata_irq_out u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_q),
        .dis_i  (dis_q),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/ata_irq_ctrl_chk.sv
// Module: property checker for ata_irq_ctrl, attached with bind.
// Observes ports plus the pending flag and disable bit of the instance.
module ata_irq_ctrl_chk #(
    parameter int unsigned N_SRC   = 2,
    parameter int unsigned CTL_W   = 8,
    parameter int unsigned DIS_BIT = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] raise_i,
    input logic [N_SRC-1:0] clear_i,
    input logic             stat_rd_i,
    input logic             busy_i,
    input logic             cmd_wr_i,
    input logic             ctl_wr_i,
    input logic [CTL_W-1:0] ctl_data_i,
    input logic             irq_o,
    input logic             pend_q,
    input logic             dis_q
);

    // R2 and R10: any raise leaves the flag set, whatever else happens
    a_r2_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|raise_i) |=> pend_q);

    // R4: a device clear with no raise empties the flag
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((|clear_i) && !(|raise_i)) |=> !pend_q);

    // R5: an idle status read with no raise empties the flag
    a_r5_stat_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !busy_i && !(|raise_i)) |=> !pend_q);

    // R6: a busy status read alone keeps a pending request
    a_r6_stat_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && busy_i && pend_q && !(|clear_i) && !cmd_wr_i) |=> pend_q);

    // R7: a command write with no raise empties the flag
    a_r7_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && !(|raise_i)) |=> !pend_q);

    // R8: a control write stores the decoded bit
    a_r8_dis_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i |=> (dis_q == $past(ctl_data_i[DIS_BIT])));

    // R8: while disabled the line stays low in the following cycle
    a_r8_masked_low: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q |=> !irq_o);

    // R11: no request without a pending flag in the cycle before
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q |=> !irq_o);

endmodule

bind ata_irq_ctrl ata_irq_ctrl_chk #(
    .N_SRC   (N_SRC),
    .CTL_W   (CTL_W),
    .DIS_BIT (DIS_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .raise_i    (raise_i),
    .clear_i    (clear_i),
    .stat_rd_i  (stat_rd_i),
    .busy_i     (busy_i),
    .cmd_wr_i   (cmd_wr_i),
    .ctl_wr_i   (ctl_wr_i),
    .ctl_data_i (ctl_data_i),
    .irq_o      (irq_o),
    .pend_q     (pend_q),
    .dis_q      (dis_q)
);

// File: tb/sim_ata_irq_ctrl.sv
// Directed bench for ata_irq_ctrl. Inputs change on falling edges, and
// outputs are sampled on falling edges.
module sim_ata_irq_ctrl;

    localparam time         CLK_PERIOD = 10ns;
    localparam int unsigned N_SRC      = 2;
    localparam int unsigned CTL_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC-1:0] raise_i = '0;
    logic [N_SRC-1:0] clear_i = '0;
    logic             stat_rd_i = 1'b0;
    logic             busy_i = 1'b0;
    logic             cmd_wr_i = 1'b0;
    logic             ctl_wr_i = 1'b0;
    logic [CTL_W-1:0] ctl_data_i = '0;
    logic             irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_irq_ctrl #(.N_SRC(N_SRC), .CTL_W(CTL_W), .DIS_BIT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .clear_i(clear_i),
        .stat_rd_i(stat_rd_i), .busy_i(busy_i), .cmd_wr_i(cmd_wr_i),
        .ctl_wr_i(ctl_wr_i), .ctl_data_i(ctl_data_i), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_o=%b expected %b", req, got, exp);
        end
    endtask

    // Advance n falling edges (one clock edge each)
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drop every strobe back to idle
    task automatic idle();
        raise_i = '0; clear_i = '0; stat_rd_i = 1'b0;
        cmd_wr_i = 1'b0; ctl_wr_i = 1'b0;
    endtask

    // One-cycle pulse helpers: drive, let one edge pass, release
    task automatic pulse_raise(input int src);
        raise_i[src] = 1'b1; step(1); idle();
    endtask
    task automatic ctl_write(input logic [CTL_W-1:0] d);
        ctl_wr_i = 1'b1; ctl_data_i = d; step(1); idle();
    endtask

    // Bring up a pending, visible request (line high when done)
    task automatic make_pending();
        pulse_raise(0); step(1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle(); ctl_data_i = '0; step(3);
        rst_n = 1'b1; step(1);
        chk("R1 reset low", irq_o, 1'b0);
        step(1);
        chk("R1 stays low", irq_o, 1'b0);
    endtask

    task automatic t_raise();
        pulse_raise(1);
        chk("R2 one edge after raise", irq_o, 1'b0);
        step(1);
        chk("R2 line high", irq_o, 1'b1);
    endtask

    task automatic t_double_raise();
        pulse_raise(0);
        chk("R3 after second raise", irq_o, 1'b1);
        step(1);
        chk("R3 still high", irq_o, 1'b1);
    endtask

    task automatic t_clear();
        clear_i[1] = 1'b1; step(1); idle();
        chk("R4 one edge after clear", irq_o, 1'b1);
        step(1);
        chk("R4 line low", irq_o, 1'b0);
    endtask

    task automatic t_stat_idle();
        make_pending();
        busy_i = 1'b0; stat_rd_i = 1'b1; step(1); idle(); step(1);
        chk("R5 idle status read clears", irq_o, 1'b0);
    endtask

    task automatic t_stat_busy();
        make_pending();
        busy_i = 1'b1; stat_rd_i = 1'b1; step(1); idle(); step(1);
        chk("R6 busy status read ignored", irq_o, 1'b1);
        busy_i = 1'b0;
        clear_i[0] = 1'b1; step(1); idle(); step(1);
    endtask

    task automatic t_cmd();
        make_pending();
        cmd_wr_i = 1'b1; step(1); idle(); step(1);
        chk("R7 command write clears", irq_o, 1'b0);
    endtask

    task automatic t_mask();
        make_pending();
        ctl_write(8'h02); step(1);
        chk("R8 disabled line low", irq_o, 1'b0);
        ctl_write(8'h00); step(1);
        chk("R8 reenabled line high", irq_o, 1'b1);
        cmd_wr_i = 1'b1; step(1); idle(); step(1);
    endtask

    task automatic t_masked_raise();
        ctl_write(8'h02);
        pulse_raise(1); step(1);
        chk("R9 raise while disabled hidden", irq_o, 1'b0);
        ctl_write(8'h00); step(1);
        chk("R9 request appears on enable", irq_o, 1'b1);
        clear_i[0] = 1'b1; step(1); idle(); step(1);
    endtask

    task automatic t_race();
        busy_i = 1'b0;
        raise_i[0] = 1'b1; clear_i = '1; cmd_wr_i = 1'b1; stat_rd_i = 1'b1;
        step(1); idle(); step(1);
        chk("R10 raise beats all clears", irq_o, 1'b1);
        raise_i[1] = 1'b1; clear_i[0] = 1'b1; step(1); idle(); step(1);
        chk("R10 raise beats clear while pending", irq_o, 1'b1);
        clear_i[0] = 1'b1; step(1); idle(); step(1);
        chk("R11 low after flag cleared", irq_o, 1'b0);
    endtask

    task automatic t_other_bits();
        make_pending();
        ctl_write(8'hFD); step(1);
        chk("R12 other control bits ignored", irq_o, 1'b1);
        ctl_write(8'h02); step(1);
        chk("R12 decoded bit still masks", irq_o, 1'b0);
        ctl_write(8'h00); step(1);
        cmd_wr_i = 1'b1; step(1); idle(); step(1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        step(1);
        t_reset();
        t_raise();
        t_double_raise();
        t_clear();
        t_stat_idle();
        t_stat_busy();
        t_cmd();
        t_mask();
        t_masked_raise();
        t_race();
        t_other_bits();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule